// File: doc/BRIEF.md
# Interrupt Take Selector

This block decides, for one hardware thread, whether an interrupt can be taken now and at which privilege level it would be handled. It receives the current privilege level, the full interrupt pending and enable vectors, the machine-level delegation mask, the two global enable bits (machine and supervisor) and a flag that says whether supervisor mode exists. The pending vector is split into two sets that are computed side by side. The machine set holds the interrupts that are pending, enabled and not delegated. The supervisor set holds the interrupts that are pending, enabled and delegated.

Each set is gated by a rule that depends on the current privilege. An interrupt aimed at a higher privilege than the current one is always allowed. An interrupt aimed at the current privilege needs that level's global enable bit. An interrupt aimed at a lower privilege is blocked. Machine interrupts win over supervisor interrupts. The block outputs the winning set, its target privilege and a 4-bit cause code from a fixed-priority encoder.

The decision is registered once, so the trap logic that follows sees stable values on the cycle after the inputs are sampled.

Top module: `irq_take_select`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, take_vld, take_priv, take_set and take_cause are all zero.
- R2: The machine set is irq_pend AND irq_en AND NOT deleg_mask. When the machine target is chosen, take_priv is 2'b11 and take_set is exactly that set.
- R3: The supervisor set is irq_pend AND irq_en AND deleg_mask, using the full vectors, so a machine source such as bit 7 can be delegated. When the supervisor target is chosen, take_priv is 2'b01 and take_set is exactly that set.
- R4: When cur_priv is machine (2'b11), machine interrupts are taken only if m_gie is 1.
- R5: When cur_priv is supervisor (2'b01) or user (2'b00), machine interrupts are taken whatever the value of m_gie.
- R6: Supervisor interrupts are taken in user mode, and in supervisor mode only when s_gie is 1. They are never taken in machine mode.
- R7: When both sets are non-empty and allowed, the machine target is reported.
- R8: cur_priv 2'b10 is reserved and never produces an interrupt.
- R9: Within the chosen set, take_cause is the first present bit in the order 11, 3, 7, 9, 1, 5.
- R10: If none of those six bits is set, take_cause is the lowest set bit among bits 0 to 15. If only bits above 15 are set, take_cause is 0 while take_set still shows the set.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. When no interrupt is chosen, all outputs are zero.
- R12: When smode_ok is 0, deleg_mask must be all zeros. A non-zero mask in that state is an assertion failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| irq_pend | input | XLEN | Interrupt pending vector |
| irq_en | input | XLEN | Interrupt enable vector |
| deleg_mask | input | XLEN | Machine-to-supervisor delegation mask |
| m_gie | input | 1 | Global machine interrupt enable |
| s_gie | input | 1 | Global supervisor interrupt enable |
| smode_ok | input | 1 | Supervisor mode is implemented |
| take_vld | output | 1 | An interrupt can be taken |
| take_priv | output | 2 | Target privilege (11 machine, 01 supervisor, 00 when none) |
| take_set | output | XLEN | Masked pending set for the target |
| take_cause | output | 4 | Selected cause code |

## Verification
The assertions assume that the delegation mask is zero whenever supervisor mode is absent. They also assume that the inputs are held steady across each sampling edge. The privilege checks compare the inputs at one edge with the registered outputs at the next edge, so they rely on the one-cycle latency.

The stimulus changes inputs only on falling edges. It uses smode_ok at 0 only together with a zero delegation mask. The reserved privilege code is applied on purpose, and its expected result is no interrupt.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_t;

    localparam int CAUSE_W = 4;
    localparam int ENC_MAX = 16;
    localparam int PRIO_N  = 6;

    // Fixed priority list of cause codes, entry 0 is the most urgent.
    function automatic logic [CAUSE_W-1:0] prio_code(input int idx);
        logic [CAUSE_W-1:0] c;
        case (idx)
            0:       c = 4'd11;
            1:       c = 4'd3;
            2:       c = 4'd7;
            3:       c = 4'd9;
            4:       c = 4'd1;
            default: c = 4'd5;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_set_split.sv
module irq_set_split #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pend,
    input  logic [XLEN-1:0] en,
    input  logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] m_set,
    output logic [XLEN-1:0] s_set,
    output logic            m_any,
    output logic            s_any
);
    logic [XLEN-1:0] live;

    always_comb begin
        live  = pend & en;
        m_set = live & ~mask;
        s_set = live & mask;
        m_any = |m_set;
        s_any = |s_set;
    end
endmodule

// File: rtl/irq_priv_gate.sv
module irq_priv_gate
    import irq_take_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       m_gie,
    input  logic       s_gie,
    output logic       m_ok,
    output logic       s_ok
);
    always_comb begin
        m_ok = 1'b0;
        s_ok = 1'b0;
        case (priv_t'(cur_priv))
            PRIV_M: m_ok = m_gie;
            PRIV_S: begin
                m_ok = 1'b1;
                s_ok = s_gie;
            end
            PRIV_U: begin
                m_ok = 1'b1;
                s_ok = 1'b1;
            end
            default: begin
                m_ok = 1'b0;
                s_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_cause_enc.sv
module irq_cause_enc
    import irq_take_pkg::*;
#(
    parameter int ENC_N = 16
) (
    input  logic [ENC_N-1:0]   set_lo,
    output logic [CAUSE_W-1:0] cause
);
    logic [PRIO_N-1:0] prio_hit;

    genvar g;
    generate
        for (g = 0; g < PRIO_N; g++) begin : g_hit
            localparam int CODE = int'(prio_code(g));
            if (CODE < ENC_N) begin : g_in
                assign prio_hit[g] = set_lo[CODE];
            end else begin : g_out
                assign prio_hit[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        cause = '0;
        // The lowest set bit is the fallback; the reverse scan lets the lowest bit win.
        for (int i = ENC_N - 1; i >= 0; i--) begin
            if (set_lo[i]) cause = CAUSE_W'(i);
        end
        // The listed codes override the fallback; the reverse scan lets the most urgent win.
        for (int k = PRIO_N - 1; k >= 0; k--) begin
            if (prio_hit[k]) cause = prio_code(k);
        end
    end
endmodule

// File: rtl/irq_take_select.sv
module irq_take_select
    import irq_take_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cur_priv,
    input  logic [XLEN-1:0]     irq_pend,
    input  logic [XLEN-1:0]     irq_en,
    input  logic [XLEN-1:0]     deleg_mask,
    input  logic                m_gie,
    input  logic                s_gie,
    input  logic                smode_ok,
    output logic                take_vld,
    output logic [1:0]          take_priv,
    output logic [XLEN-1:0]     take_set,
    output logic [CAUSE_W-1:0]  take_cause
);
    localparam int ENC_N = (XLEN < ENC_MAX) ? XLEN : ENC_MAX;

    typedef struct packed {
        logic               vld;
        logic [1:0]         priv;
        logic [XLEN-1:0]    set;
        logic [CAUSE_W-1:0] cause;
    } take_t;

    take_t take_d, take_q;

    logic [XLEN-1:0]    m_set, s_set, sel_set;
    logic               m_any, s_any, m_ok, s_ok;
    logic               pick_m, pick_s;
    logic [CAUSE_W-1:0] enc_cause;

    irq_set_split #(.XLEN(XLEN)) split_i (
        .pend  (irq_pend),
        .en    (irq_en),
        .mask  (deleg_mask),
        .m_set (m_set),
        .s_set (s_set),
        .m_any (m_any),
        .s_any (s_any)
    );

    irq_priv_gate gate_i (
        .cur_priv (cur_priv),
        .m_gie    (m_gie),
        .s_gie    (s_gie),
        .m_ok     (m_ok),
        .s_ok     (s_ok)
    );

    always_comb begin
        pick_m  = m_ok && m_any;
        pick_s  = !pick_m && s_ok && s_any;
        sel_set = pick_m ? m_set : (pick_s ? s_set : '0);
    end

    irq_cause_enc #(.ENC_N(ENC_N)) enc_i (
        .set_lo (sel_set[ENC_N-1:0]),
        .cause  (enc_cause)
    );

    always_comb begin
        take_d = '0;
        if (pick_m || pick_s) begin
            take_d.vld   = 1'b1;
            take_d.priv  = pick_m ? PRIV_M : PRIV_S;
            take_d.set   = sel_set;
            take_d.cause = enc_cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) take_q <= '0;
        else        take_q <= take_d;
    end

    assign take_vld   = take_q.vld;
    assign take_priv  = take_q.priv;
    assign take_set   = take_q.set;
    assign take_cause = take_q.cause;

    // Delegation is only legal when supervisor mode exists.
    assert_deleg_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !smode_ok |-> (deleg_mask == '0));

    // A valid output always carries a non-empty set.
    assert_vld_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (take_set != '0));

    // Running in machine mode never yields a supervisor target.
    assert_mmode_no_s_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_M) |=> (!take_vld || take_priv == PRIV_M));

    // The reserved privilege code produces nothing.
    assert_rsv_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_RSV) |=> !take_vld);

    // Machine mode with the global enable clear takes nothing.
    assert_mgie_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_M && !m_gie) |=> !take_vld);

    // The reported cause is a member of the reported set when low bits exist.
    assert_cause_member_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && take_set[ENC_N-1:0] != '0) |-> take_set[take_cause]);

endmodule

// File: tb/irq_take_select_tb.sv
`timescale 1ns/1ps
module irq_take_select_tb_top;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cur_priv = 2'b00;
    logic [XLEN-1:0] irq_pend = '0, irq_en = '0, deleg_mask = '0;
    logic            m_gie = 1'b0, s_gie = 1'b0, smode_ok = 1'b1;
    logic            take_vld;
    logic [1:0]      take_priv;
    logic [XLEN-1:0] take_set;
    logic [3:0]      take_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_take_select #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .irq_pend(irq_pend),
        .irq_en(irq_en), .deleg_mask(deleg_mask), .m_gie(m_gie), .s_gie(s_gie),
        .smode_ok(smode_ok), .take_vld(take_vld), .take_priv(take_priv),
        .take_set(take_set), .take_cause(take_cause)
    );

    localparam logic [63:0] ALL = '1;

    task automatic chk(input string req, input logic v, input logic [1:0] p,
                       input logic [63:0] s, input logic [3:0] c);
        checks++;
        if (take_vld !== v || take_priv !== p || take_set !== s || take_cause !== c) begin
            errors++;
            $display("FAIL %s: got vld=%0b priv=%0b set=%h cause=%0d exp vld=%0b priv=%0b set=%h cause=%0d",
                     req, take_vld, take_priv, take_set, take_cause, v, p, s, c);
        end
    endtask

    task automatic apply(input logic [1:0] pr, input logic [63:0] pd, input logic [63:0] en,
                         input logic [63:0] dm, input logic mg, input logic sg);
        @(negedge clk);
        cur_priv = pr; irq_pend = pd; irq_en = en; deleg_mask = dm;
        m_gie = mg; s_gie = sg;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        cur_priv = 2'b00; irq_pend = ALL; irq_en = ALL;
        repeat (3) @(posedge clk);
        #1 chk("R1 in reset", 0, 2'b00, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        irq_pend = '0;
        @(posedge clk); #1 chk("R1 after reset", 0, 2'b00, 0, 0);
    endtask

    task automatic t_mmode();
        apply(2'b11, 64'h80, 64'h80, 0, 0, 0);
        chk("R4 mgie off", 0, 2'b00, 0, 0);
        apply(2'b11, 64'h80, 64'h80, 0, 1, 0);
        chk("R4 mgie on", 1, 2'b11, 64'h80, 4'd7);
        apply(2'b11, 64'h888, 64'h80, 0, 1, 0);
        chk("R2 enable masks", 1, 2'b11, 64'h80, 4'd7);
    endtask

    task automatic t_below_m();
        apply(2'b01, 64'h8, ALL, 0, 0, 0);
        chk("R5 smode mgie off", 1, 2'b11, 64'h8, 4'd3);
        apply(2'b00, 64'h8, ALL, 0, 0, 0);
        chk("R5 umode mgie off", 1, 2'b11, 64'h8, 4'd3);
    endtask

    task automatic t_smode();
        apply(2'b11, 64'h20, ALL, 64'h222, 1, 1);
        chk("R6 never in mmode", 0, 2'b00, 0, 0);
        apply(2'b01, 64'h20, ALL, 64'h222, 1, 0);
        chk("R6 smode sgie off", 0, 2'b00, 0, 0);
        apply(2'b01, 64'h20, ALL, 64'h222, 0, 1);
        chk("R6 smode sgie on", 1, 2'b01, 64'h20, 4'd5);
        apply(2'b00, 64'h22, 64'h20, 64'h222, 0, 0);
        chk("R3 umode, enable masks", 1, 2'b01, 64'h20, 4'd5);
        apply(2'b00, 64'h80, ALL, 64'h80, 0, 0);
        chk("R3 machine timer delegated", 1, 2'b01, 64'h80, 4'd7);
    endtask

    task automatic t_priority();
        apply(2'b00, 64'h822, ALL, 64'h222, 0, 0);
        chk("R7 machine wins", 1, 2'b11, 64'h800, 4'd11);
        apply(2'b01, 64'h822, ALL, 64'h222, 0, 1);
        chk("R7 machine wins in smode", 1, 2'b11, 64'h800, 4'd11);
    endtask

    task automatic t_reserved();
        apply(2'b10, ALL, ALL, 64'h222, 1, 1);
        chk("R8 reserved priv", 0, 2'b00, 0, 0);
    endtask

    task automatic t_cause_order();
        logic [63:0] p = 64'hAAA;
        logic [3:0]  exp [6] = '{4'd11, 4'd3, 4'd7, 4'd9, 4'd1, 4'd5};
        for (int i = 0; i < 6; i++) begin
            apply(2'b01, p, ALL, 0, 0, 0);
            chk("R9 priority order", 1, 2'b11, p, exp[i]);
            p[exp[i]] = 1'b0;
        end
    endtask

    task automatic t_fallback();
        apply(2'b00, 64'h2010, ALL, 0, 0, 0);
        chk("R10 lowest bit", 1, 2'b11, 64'h2010, 4'd4);
        apply(2'b00, 64'h1 << 40, ALL, 0, 0, 0);
        chk("R10 high bit only", 1, 2'b11, 64'h1 << 40, 4'd0);
    endtask

    task automatic t_latency();
        apply(2'b00, 64'h8, ALL, 0, 0, 0);
        chk("R11 first value", 1, 2'b11, 64'h8, 4'd3);
        @(negedge clk);
        irq_pend = 64'h800;
        #1 chk("R11 held before edge", 1, 2'b11, 64'h8, 4'd3);
        @(posedge clk); #1 chk("R11 updated after edge", 1, 2'b11, 64'h800, 4'd11);
        apply(2'b00, 0, ALL, 0, 0, 0);
        chk("R11 none is zero", 0, 2'b00, 0, 0);
    endtask

    // R12: with supervisor mode absent the mask is held at zero.
    task automatic t_no_smode();
        @(negedge clk); smode_ok = 1'b0;
        apply(2'b00, 64'h8, ALL, 0, 0, 0);
        chk("R12 no smode, zero mask", 1, 2'b11, 64'h8, 4'd3);
        @(negedge clk); smode_ok = 1'b1;
    endtask

    initial begin
        t_reset();
        t_mmode();
        t_below_m();
        t_smode();
        t_priority();
        t_reserved();
        t_cause_order();
        t_fallback();
        t_latency();
        t_no_smode();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule